// File: doc/BRIEF.md
# Two-Packet IN Endpoint Transmit Controller

This block is the device-side controller for one IN (device-to-host) endpoint. The CPU loads data bytes into a FIFO that holds two packets. It then marks each packet ready through a byte-wide control/status register. That register also selects stall, isochronous operation, rate-feedback interrupt mode and automatic ready-marking, and it carries a flush command. The CPU reads the same register to see whether a packet is queued, whether bytes are pending, and whether an isochronous underrun has occurred.

On the bus side the block works at token and handshake level. An IN token gets one of three answers, each a one-cycle pulse in the cycle after the token: a data response, a NAK, or a STALL. While a packet is being sent, the serializer reads its bytes one at a time and sees its length. When the serializer signals that the transmission has finished, the block drops that packet from the FIFO. Serialization, CRC and handshake timing on the wire belong to neighbouring blocks.

Top module: `in_ep_tx_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and no response pulse is active.
- R2: The register bit positions are fixed. Bit 2 (stall), bit 3 (isochronous), bit 4 (rate-feedback select) and bit 7 (auto-ready) can be read and written. Bit 6 (flush) always reads 0. Writes to bit 5 are ignored.
- R3: Writing 1 to bit 0 turns the bytes loaded so far, possibly none, into a queued packet, up to two packets. Bit 0 reads 1 while at least one packet is queued. Writing 0 to bit 0 does nothing. A commit when two packets are already queued is ignored.
- R4: With bit 7 set, the packet is queued automatically on the byte write that brings the loaded count equal to `max_pkt_len`.
- R5: Bit 5 reads 1 while a packet is queued or uncommitted bytes are loaded, and 0 otherwise.
- R6: While bit 2 is 1, an IN token is answered by `rsp_stall` in the next cycle and by no other response.
- R7: When no transmission is running, an IN token that finds a queued packet and no stall is answered by `rsp_data` in the next cycle. The oldest packet's length then appears on `tx_len`, and its bytes appear in order on `tx_rdata`, advanced by `tx_rd`.
- R8: A token that finds no packet and no stall gets `rsp_nak` when bit 3 is 0. When bit 3 is 1 it gets no response and sets bit 1 instead. Writing 0 to bit 1 clears it; writing 1 to bit 1 has no effect.
- R9: `tx_done` ends the transmission and removes the oldest packet. If a second packet was queued, it becomes the current one and bit 0 stays 1.
- R10: Writing 1 to bit 6 while idle removes the oldest queued packet. With one packet queued this empties the FIFO; with two, the newer one remains. With no packet queued the write has no effect.
- R11: A flush written during a transmission does not disturb the packet being sent. It takes effect in the cycle after `tx_done`.
- R12: An IN token that arrives during a transmission is ignored. A token in the same cycle as a flush that takes effect is treated as if no packet were queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read value |
| fifo_wr | input | 1 | Load one data byte |
| fifo_wdata | input | DATA_W | Byte being loaded |
| max_pkt_len | input | CNT_W | Packet size for automatic ready-marking |
| in_token | input | 1 | IN token received, one-cycle pulse |
| tx_rd | input | 1 | Advance to the next byte of the current packet |
| tx_done | input | 1 | Transmission finished |
| tx_rdata | output | DATA_W | Current byte of the packet being sent |
| tx_len | output | CNT_W | Length of the oldest packet |
| rsp_data | output | 1 | Data response pulse |
| rsp_nak | output | 1 | NAK response pulse |
| rsp_stall | output | 1 | STALL response pulse |

## Verification
The bench sweeps every pair of packet lengths from zero to the maximum. This catches a wrong slot choice after a pop: such a design would send the second packet's bytes or length when the first was due, or clear ready while a packet remains. The automatic ready-marking sweep checks every size limit, which exposes an off-by-one that marks a packet one byte early or late. The flush cases check the one-packet and two-packet outcomes. A design that flushed both packets, or that flushed the packet on the wire, would show an empty register too early or a wrong length. The remaining cases check the isochronous underrun flag and its write-0 clear, the precedence of stall, and tokens that arrive mid-transmission, where a careless design would restart or NAK.

// File: rtl/in_ep_pkg.sv
package in_ep_pkg;
  // Register bit positions; software decodes them, so they are fixed.
  localparam int BIT_RDY   = 0;
  localparam int BIT_UNDR  = 1;
  localparam int BIT_STALL = 2;
  localparam int BIT_ISO   = 3;
  localparam int BIT_RATE  = 4;
  localparam int BIT_NE    = 5;
  localparam int BIT_FLUSH = 6;
  localparam int BIT_AUTO  = 7;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_DATA  = 2'd1,
    RSP_NAK   = 2'd2,
    RSP_STALL = 2'd3
  } resp_e;

  // Token answer chosen from the mode bits and packet availability.
  function automatic resp_e pick_rsp(input logic stall, input logic avail,
                                     input logic iso);
    if (stall)      return RSP_STALL;
    else if (avail) return RSP_DATA;
    else if (iso)   return RSP_NONE;
    else            return RSP_NAK;
  endfunction
endpackage

// File: rtl/in_ep_pkt_fifo.sv
module in_ep_pkt_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  input  logic              pop,
  input  logic              rd_adv,
  output logic              wr_accept,
  output logic [1:0]        pkt_cnt,
  output logic [CNT_W-1:0]  fill_cnt,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  rd_len
);
  logic [DATA_W-1:0] mem_q [2][DEPTH];
  logic [CNT_W-1:0]  len_q [2];
  logic              rd_slot_q;
  logic [IDX_W-1:0]  rd_idx_q;
  logic              fill_slot;
  logic              do_commit, do_pop;

  function automatic logic [1:0] cnt_next(input logic [1:0] c, input logic add,
                                          input logic sub);
    return c + {1'b0, add} - {1'b0, sub};
  endfunction

  assign fill_slot = rd_slot_q ^ (pkt_cnt == 2'd1);
  assign wr_accept = wr_en && (pkt_cnt != 2'd2) && (fill_cnt < CNT_W'(DEPTH));
  assign do_commit = commit && (pkt_cnt != 2'd2);
  assign do_pop    = pop && (pkt_cnt != 2'd0);
  assign rd_data   = mem_q[rd_slot_q][rd_idx_q];
  assign rd_len    = len_q[rd_slot_q];

  always_ff @(posedge clk) begin
    if (wr_accept) mem_q[fill_slot][fill_cnt[IDX_W-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_cnt   <= '0;
      fill_cnt  <= '0;
      rd_slot_q <= 1'b0;
      rd_idx_q  <= '0;
      len_q[0]  <= '0;
      len_q[1]  <= '0;
    end else begin
      pkt_cnt <= cnt_next(pkt_cnt, do_commit, do_pop);
      if (do_commit) begin
        len_q[fill_slot] <= fill_cnt + CNT_W'(wr_accept);
        fill_cnt         <= '0;
      end else if (wr_accept) begin
        fill_cnt <= fill_cnt + CNT_W'(1);
      end
      if (do_pop) begin
        rd_slot_q <= ~rd_slot_q;
        rd_idx_q  <= '0;
      end else if (rd_adv) begin
        rd_idx_q <= rd_idx_q + IDX_W'(1);
      end
    end
  end

  // R3
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_cnt != 2'd3);
  // R9
  pop_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !commit && pkt_cnt == 2'd2) |=> pkt_cnt == 2'd1);
  // R3
  full_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !pop && pkt_cnt == 2'd2) |=> pkt_cnt == 2'd2);
endmodule

// File: rtl/in_ep_csr.sv
module in_ep_csr
  import in_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csr_wr,
  input  logic [7:0] csr_wdata,
  input  logic       undr_set,
  output logic       stall_q,
  output logic       iso_q,
  output logic       rate_q,
  output logic       auto_q,
  output logic       undr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
      iso_q   <= 1'b0;
      rate_q  <= 1'b0;
      auto_q  <= 1'b0;
      undr_q  <= 1'b0;
    end else begin
      if (csr_wr) begin
        stall_q <= csr_wdata[BIT_STALL];
        iso_q   <= csr_wdata[BIT_ISO];
        rate_q  <= csr_wdata[BIT_RATE];
        auto_q  <= csr_wdata[BIT_AUTO];
      end
      if (undr_set)                              undr_q <= 1'b1;
      else if (csr_wr && !csr_wdata[BIT_UNDR])   undr_q <= 1'b0;
    end
  end

  // R8
  undr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !csr_wdata[BIT_UNDR] && !undr_set) |=> !undr_q);
  // R8
  undr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (undr_q && !(csr_wr && !csr_wdata[BIT_UNDR])) |=> undr_q);
endmodule

// File: rtl/in_ep_tx_ctrl.sv
module in_ep_tx_ctrl
  import in_ep_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MAX_PKT = 4,
  localparam int CNT_W = $clog2(MAX_PKT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [7:0]        csr_wdata,
  output logic [7:0]        csr_rdata,
  input  logic              fifo_wr,
  input  logic [DATA_W-1:0] fifo_wdata,
  input  logic [CNT_W-1:0]  max_pkt_len,
  input  logic              in_token,
  input  logic              tx_rd,
  input  logic              tx_done,
  output logic [DATA_W-1:0] tx_rdata,
  output logic [CNT_W-1:0]  tx_len,
  output logic              rsp_data,
  output logic              rsp_nak,
  output logic              rsp_stall
);
  logic             busy_q, flush_pend_q;
  logic             stall_q, iso_q, rate_q, auto_q, undr_q;
  logic             wr_accept;
  logic [1:0]       pkt_cnt;
  logic [CNT_W-1:0] fill_cnt;
  // Named internal events for the assertions.
  logic             flush_req, flush_now, tx_end, pop, tok_ok, has_pkt;
  logic             auto_commit, commit, undr_set, tx_start;
  resp_e            sel;

  function automatic logic hits_limit(input logic [CNT_W-1:0] cnt,
                                      input logic [CNT_W-1:0] lim);
    return (cnt + CNT_W'(1)) == lim;
  endfunction

  assign flush_req   = csr_wr && csr_wdata[BIT_FLUSH];
  assign flush_now   = !busy_q && (flush_req || flush_pend_q);
  assign tx_end      = busy_q && tx_done;
  assign pop         = tx_end || flush_now;
  assign tok_ok      = in_token && !busy_q;
  assign has_pkt     = (pkt_cnt != 2'd0) && !flush_now;
  assign sel         = pick_rsp(stall_q, has_pkt, iso_q);
  assign tx_start    = tok_ok && (sel == RSP_DATA);
  assign undr_set    = tok_ok && (sel == RSP_NONE);
  assign auto_commit = auto_q && wr_accept && hits_limit(fill_cnt, max_pkt_len);
  assign commit      = (csr_wr && csr_wdata[BIT_RDY]) || auto_commit;

  in_ep_pkt_fifo #(.DATA_W(DATA_W), .DEPTH(MAX_PKT)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fifo_wr), .wr_data(fifo_wdata),
    .commit(commit), .pop(pop), .rd_adv(busy_q && tx_rd),
    .wr_accept(wr_accept), .pkt_cnt(pkt_cnt), .fill_cnt(fill_cnt),
    .rd_data(tx_rdata), .rd_len(tx_len)
  );

  in_ep_csr u_csr (
    .clk(clk), .rst_n(rst_n),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata), .undr_set(undr_set),
    .stall_q(stall_q), .iso_q(iso_q), .rate_q(rate_q),
    .auto_q(auto_q), .undr_q(undr_q)
  );

  always_comb begin
    csr_rdata            = '0;
    csr_rdata[BIT_RDY]   = pkt_cnt != 2'd0;
    csr_rdata[BIT_UNDR]  = undr_q;
    csr_rdata[BIT_STALL] = stall_q;
    csr_rdata[BIT_ISO]   = iso_q;
    csr_rdata[BIT_RATE]  = rate_q;
    csr_rdata[BIT_NE]    = (pkt_cnt != 2'd0) || (fill_cnt != '0);
    csr_rdata[BIT_AUTO]  = auto_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      flush_pend_q <= 1'b0;
      rsp_data     <= 1'b0;
      rsp_nak      <= 1'b0;
      rsp_stall    <= 1'b0;
    end else begin
      if (tx_start)    busy_q <= 1'b1;
      else if (tx_end) busy_q <= 1'b0;
      flush_pend_q <= busy_q && (flush_pend_q || flush_req);
      rsp_data     <= tx_start;
      rsp_nak      <= tok_ok && (sel == RSP_NAK);
      rsp_stall    <= tok_ok && (sel == RSP_STALL);
    end
  end

  // R6
  stall_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_token && !busy_q && stall_q) |=> (rsp_stall && !rsp_data && !rsp_nak));
  // R7
  data_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_token && !busy_q && !stall_q && pkt_cnt != 2'd0 && !flush_now)
      |=> (rsp_data && busy_q));
  // R8
  nak_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_token && !busy_q && !stall_q && !iso_q && pkt_cnt == 2'd0) |=> rsp_nak);
  // R8
  undr_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_token && !busy_q && !stall_q && iso_q && pkt_cnt == 2'd0)
      |=> (undr_q && !rsp_nak && !rsp_data));
  // R12
  busy_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_token && busy_q) |=> !(rsp_data || rsp_nak || rsp_stall));
  // R11
  flush_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && flush_req && !tx_done && pkt_cnt == 2'd2) |=> pkt_cnt == 2'd2);
  // R7
  rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_data, rsp_nak, rsp_stall}));
endmodule

// File: tb/tb_in_ep_tx_ctrl.sv
module tb_in_ep_tx_ctrl;
  localparam int MAXP = 4;
  localparam int CW   = $clog2(MAXP + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          csr_wr = 1'b0;
  logic [7:0]    csr_wdata = '0;
  logic [7:0]    csr_rdata;
  logic          fifo_wr = 1'b0;
  logic [7:0]    fifo_wdata = '0;
  logic [CW-1:0] max_pkt_len = CW'(MAXP);
  logic          in_token = 1'b0, tx_rd = 1'b0, tx_done = 1'b0;
  logic [7:0]    tx_rdata;
  logic [CW-1:0] tx_len;
  logic          rsp_data, rsp_nak, rsp_stall;
  int            nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  in_ep_tx_ctrl #(.DATA_W(8), .MAX_PKT(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .max_pkt_len(max_pkt_len), .in_token(in_token), .tx_rd(tx_rd),
    .tx_done(tx_done), .tx_rdata(tx_rdata), .tx_len(tx_len),
    .rsp_data(rsp_data), .rsp_nak(rsp_nak), .rsp_stall(rsp_stall)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int b, input int i);
    return 8'((a * 37 + b * 11 + i * 5 + 3) & 8'hff);
  endfunction

  task automatic csr_write(input logic [7:0] v);
    @(negedge clk); csr_wr = 1'b1; csr_wdata = v;
    @(negedge clk); csr_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] v);
    @(negedge clk); fifo_wr = 1'b1; fifo_wdata = v;
    @(negedge clk); fifo_wr = 1'b0;
  endtask

  // Returns {stall, nak, data} seen the cycle after the token.
  task automatic token(output logic [2:0] r);
    @(negedge clk); in_token = 1'b1;
    @(negedge clk); in_token = 1'b0;
    r = {rsp_stall, rsp_nak, rsp_data};
  endtask

  task automatic finish_tx();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic send_check(input string req, input int len, input int a,
                            input int b);
    logic [2:0] r;
    token(r);
    check({req, " data response"}, r, 3'b001);
    check({req, " length"}, tx_len, len);
    for (int i = 0; i < len; i++) begin
      check({req, " byte"}, tx_rdata, pat(a, b, i));
      tx_rd = 1'b1;
      @(negedge clk); tx_rd = 1'b0;
    end
    finish_tx();
  endtask

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [2:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 csr", csr_rdata, 8'h00);
    check("R1 rsp", {rsp_stall, rsp_nak, rsp_data}, 3'b000);

    // R2 access types
    csr_write(8'h9C);
    check("R2 rw bits", csr_rdata, 8'h9C);
    csr_write(8'h60);
    check("R2 ro/wo bits", csr_rdata, 8'h00);

    // R5 partial bytes, R3 commit and write-0
    push(8'hA1); push(8'hA2);
    check("R5 partial", csr_rdata, 8'h20);
    csr_write(8'h00);
    check("R3 write0 no commit", csr_rdata, 8'h20);
    csr_write(8'h01);
    check("R3 commit", csr_rdata, 8'h21);
    token(r);
    check("R7 data", r, 3'b001);
    check("R7 len", tx_len, 2);
    check("R7 byte0", tx_rdata, 8'hA1);
    finish_tx();
    check("R9 empty", csr_rdata, 8'h00);

    // R3 R7 R9 sweep over both packet lengths
    for (int l1 = 0; l1 <= MAXP; l1++) begin
      for (int l2 = 0; l2 <= MAXP; l2++) begin
        for (int i = 0; i < l1; i++) push(pat(l1, l2, i));
        csr_write(8'h01);
        for (int i = 0; i < l2; i++) push(pat(l2, l1 + 9, i));
        csr_write(8'h01);
        push(8'h55);
        csr_write(8'h01);
        check("R3 two queued", csr_rdata, 8'h21);
        send_check("R7 first", l1, l1, l2);
        check("R9 second ready", csr_rdata, 8'h21);
        send_check("R9 second", l2, l2, l1 + 9);
        check("R9 drained", csr_rdata, 8'h00);
      end
    end

    // R4 auto-ready for every size limit
    for (int m = 1; m <= MAXP; m++) begin
      max_pkt_len = CW'(m);
      csr_write(8'h80);
      for (int i = 0; i < m - 1; i++) push(pat(m, 50, i));
      check("R4 not yet", csr_rdata[0], 1'b0);
      push(pat(m, 50, m - 1));
      check("R4 auto ready", csr_rdata, 8'hA1);
      send_check("R4 auto pkt", m, m, 50);
      csr_write(8'h00);
    end
    max_pkt_len = CW'(MAXP);

    // R8 NAK and isochronous underrun
    token(r);
    check("R8 nak", r, 3'b010);
    csr_write(8'h08);
    token(r);
    check("R8 iso silent", r, 3'b000);
    check("R8 underrun set", csr_rdata, 8'h0A);
    csr_write(8'h0A);
    check("R8 write1 keeps", csr_rdata, 8'h0A);
    csr_write(8'h08);
    check("R8 write0 clears", csr_rdata, 8'h08);
    csr_write(8'h00);

    // R6 stall precedence
    push(pat(7, 7, 0));
    csr_write(8'h01);
    csr_write(8'h04);
    token(r);
    check("R6 stall", r, 3'b100);
    check("R6 packet kept", csr_rdata, 8'h25);
    csr_write(8'h00);
    send_check("R6 after stall", 1, 7, 7);

    // R10 flush
    push(8'h11); csr_write(8'h01);
    csr_write(8'h40);
    check("R10 one flushed", csr_rdata, 8'h00);
    csr_write(8'h40);
    check("R10 empty flush", csr_rdata, 8'h00);
    push(8'h22); csr_write(8'h01);
    for (int i = 0; i < 3; i++) push(pat(3, 20, i));
    csr_write(8'h01);
    csr_write(8'h40);
    check("R10 newer kept", csr_rdata, 8'h21);
    send_check("R10 newer sent", 3, 3, 20);
    check("R10 drained", csr_rdata, 8'h00);

    // R11 deferred flush
    for (int i = 0; i < 2; i++) push(pat(2, 30, i));
    csr_write(8'h01);
    push(8'h77); csr_write(8'h01);
    token(r);
    check("R11 data", r, 3'b001);
    csr_write(8'h40);
    check("R11 held len", tx_len, 2);
    check("R11 held byte", tx_rdata, pat(2, 30, 0));
    check("R11 both queued", csr_rdata, 8'h21);
    finish_tx();
    @(negedge clk);
    check("R11 flushed after end", csr_rdata, 8'h00);

    // R12 token during transmission
    push(8'h3C); csr_write(8'h01);
    token(r);
    check("R12 first", r, 3'b001);
    token(r);
    check("R12 ignored", r, 3'b000);
    csr_write(8'h08);
    token(r);
    check("R12 no underrun", csr_rdata, 8'h29);
    csr_write(8'h00);
    finish_tx();
    check("R12 drained", csr_rdata, 8'h00);

    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule